// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Controller

This block collects a set of level-sensitive interrupt sources, grouped into 32-bit words, and raises one interrupt line for each of several processors. Every processor sees the same source levels, but each has its own private set of enable words. A processor's line is high whenever at least one source is both active and enabled for that processor. Source inputs may arrive from any clock domain. They pass through a two-stage synchronizer before they are used.

Software reaches the controller through a plain single-cycle register port that has a select, a write flag, a byte address and 32-bit data. Read data is combinational from the address. Each processor owns one contiguous bank. Its enable words come first and its status words follow. The banks sit one after another from address zero. A build-time parameter chooses how word slots map to source numbers. With reversed order, the first slot of each group holds the highest-numbered word. With natural order, slot and word index match. Enables are written as whole words. There are no set or clear aliases.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Source number n is status word n/32, bit n%32. A status word read returns the synchronized level of `src_level[32*w +: 32]` for logical word w.
- R2: The bank for CPU k starts at byte k*NUM_WORDS*8. Within a bank, the enable slots sit at byte offsets 4*s for s < NUM_WORDS. The status slots follow at 4*(NUM_WORDS+s). Address bits [1:0] are ignored.
- R3: With WORD_REVERSE=1, slot s of either group holds logical word NUM_WORDS-1-s. With WORD_REVERSE=0, slot s holds logical word s.
- R4: A write to an enable slot replaces the whole 32-bit word. A later read of that slot returns the value last written.
- R5: Each CPU's enable words are separate. A write into one CPU's bank leaves every other bank unchanged.
- R6: `cpu_irq[k]` is the OR over all words of (status AND CPU k's enable). It is registered, so it changes on the clock edge after the edge that changed an enable word.
- R7: Status slots are read-only. Writing one changes no enable word and no output.
- R8: While reset is low, and right after it is released, every enable word reads zero and every `cpu_irq` bit is low.
- R9: An access at a byte address at or beyond NUM_CPUS*NUM_WORDS*8 reads zero, and a write there has no effect.
- R10: A change on `src_level` becomes visible in a status read after two clock edges. It reaches `cpu_irq` after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | 32*NUM_WORDS | Level interrupt sources, possibly asynchronous |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt line |

## Verification
The assertions assume a single register access per cycle, with the select, write flag, address and data held steady across the sampling edge. They also assume reset is driven low from time zero. They make no assumption about when `src_level` moves, because the synchronizer is the only logic that samples it. The bench drives every input on the falling clock edge. It issues accesses one at a time and keeps sources steady for at least four cycles before it compares interrupt lines. The only exceptions are the latency checks, which sample the intermediate edges on purpose.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned WORD_BYTES = 4;

  // Bytes taken by one CPU bank: an enable group plus a status group.
  function automatic int unsigned bank_bytes(input int unsigned nwords);
    return nwords * 2 * WORD_BYTES;
  endfunction

  // Which CPU bank a byte address falls into.
  function automatic int unsigned bank_index(input int unsigned addr,
                                             input int unsigned nwords);
    return addr / bank_bytes(nwords);
  endfunction

  // 32-bit slot number inside the bank (0 .. 2*nwords-1).
  function automatic int unsigned slot_index(input int unsigned addr,
                                             input int unsigned nwords);
    return (addr % bank_bytes(nwords)) / WORD_BYTES;
  endfunction

  // Logical word held by a slot, for either group, given the order mode.
  function automatic int unsigned logical_word(input int unsigned slot,
                                               input int unsigned nwords,
                                               input bit          reversed);
    int unsigned pos;
    pos = slot % nwords;
    return reversed ? (nwords - 1 - pos) : pos;
  endfunction

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import banked_irq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [WORD_W-1:0]                    wr_word,
  input  logic [WORD_BITS-1:0]                 wr_data,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  en_words
);

  logic [NUM_WORDS-1:0][WORD_BITS-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q[wr_word] <= wr_data;
    end
  end

  assign en_words = en_q;

  // R4: without a write strobe the enable words keep their value.
  assert_hold_without_write_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q));

  // R4: a strobed write lands as a whole word in the addressed slot.
  assert_write_lands_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      wr_en |=> en_q[$past(wr_word)] == $past(wr_data));

endmodule

// File: rtl/irq_any_reduce.sv
module irq_any_reduce
  import banked_irq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WORDS-1:0][WORD_BITS-1:0] en_words,
  input  logic [NUM_WORDS-1:0][WORD_BITS-1:0] stat_words,
  output logic                                irq
);

  logic [NUM_WORDS-1:0] word_hit;
  logic                 pend_any;
  logic                 irq_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_hit[w] = |(en_words[w] & stat_words[w]);
  end

  assign pend_any = |word_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

  assign irq = irq_q;

  // R6: with no enable bit set in this bank, the line is low next cycle.
  assert_no_enable_no_irq_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
      (en_words == '0) |=> !irq_q);

  // R6: with no active source at all, the line is low next cycle.
  assert_no_source_no_irq_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
      (stat_words == '0) |=> !irq_q);

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
#(
  parameter int unsigned NUM_CPUS     = 2,
  parameter int unsigned NUM_WORDS    = 4,
  parameter int unsigned ADDR_W       = 8,
  parameter bit          WORD_REVERSE = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WORDS*WORD_BITS-1:0]  src_level,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [WORD_BITS-1:0]            bus_wdata,
  output logic [WORD_BITS-1:0]            bus_rdata,
  output logic [NUM_CPUS-1:0]             cpu_irq
);

  localparam int unsigned SRC_BITS = NUM_WORDS * WORD_BITS;
  localparam int unsigned CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int unsigned WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  // ---------------- address decode ----------------
  int unsigned        dec_bank;
  int unsigned        dec_slot;
  logic               dec_hit;
  logic               dec_status;
  logic [CPU_W-1:0]   dec_cpu;
  logic [WORD_W-1:0]  dec_word;

  always_comb begin
    dec_bank   = bank_index(32'(bus_addr), NUM_WORDS);
    dec_slot   = slot_index(32'(bus_addr), NUM_WORDS);
    dec_hit    = (dec_bank < NUM_CPUS);
    dec_status = (dec_slot >= NUM_WORDS);
    dec_cpu    = CPU_W'(dec_bank);
    dec_word   = WORD_W'(logical_word(dec_slot, NUM_WORDS, WORD_REVERSE));
  end

  logic                wr_fire;
  logic [NUM_CPUS-1:0] wr_strobe;

  assign wr_fire = bus_sel && bus_wr && dec_hit && !dec_status;

  // ---------------- source synchronizer ----------------
  logic [SRC_BITS-1:0]                 stat_flat;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] stat_words;

  irq_level_sync #(.WIDTH(SRC_BITS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (src_level),
    .sync_out (stat_flat)
  );

  assign stat_words = stat_flat;

  // ---------------- per-CPU banks ----------------
  logic [NUM_CPUS-1:0][NUM_WORDS-1:0][WORD_BITS-1:0] en_all;

  for (genvar k = 0; k < NUM_CPUS; k++) begin : g_cpu
    assign wr_strobe[k] = wr_fire && (dec_cpu == CPU_W'(k));

    irq_enable_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_strobe[k]),
      .wr_word  (dec_word),
      .wr_data  (bus_wdata),
      .en_words (en_all[k])
    );

    irq_any_reduce #(.NUM_WORDS(NUM_WORDS)) u_reduce (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_words   (en_all[k]),
      .stat_words (stat_words),
      .irq        (cpu_irq[k])
    );
  end

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && dec_hit) begin
      if (dec_status) bus_rdata = stat_words[dec_word];
      else            bus_rdata = en_all[dec_cpu][dec_word];
    end
  end

  // R5: a single access never strobes more than one CPU bank.
  assert_single_bank_write_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      $onehot0(wr_strobe));

  // R7: writes aimed at status slots leave all enable state untouched.
  assert_status_write_ignored_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && dec_hit && dec_status) |=> $stable(en_all));

  // R9: writes past the last bank leave all enable state untouched.
  assert_stray_write_ignored_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !dec_hit) |=> $stable(en_all));

  // R9: reads past the last bank return zero.
  assert_stray_read_zero_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !dec_hit) |-> (bus_rdata == '0));

  // R8: every interrupt line is low while reset is applied.
  assert_reset_quiet_R8: assert property (
    @(posedge clk) !rst_n |-> (cpu_irq == '0));

endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;

  localparam int NC    = 2;
  localparam int NW    = 2;
  localparam int BANK  = NW * 8;
  localparam int TOTAL = NC * BANK;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NW*32-1:0]  src = '0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       rdata_rev, rdata_le;
  logic [NC-1:0]     irq_rev, irq_le;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // model[inst][cpu][logical word]; inst 0 = reversed order, 1 = natural
  logic [31:0] en_m [2][NC][NW];

  always #4 clk = ~clk;

  banked_irq_ctrl #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(8), .WORD_REVERSE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .src_level(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_rev), .cpu_irq(irq_rev));

  banked_irq_ctrl #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(8), .WORD_REVERSE(1'b0)) uut_le (
    .clk(clk), .rst_n(rst_n), .src_level(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_le), .cpu_irq(irq_le));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected<=50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Slot position -> logical word, written the other way round from the RTL.
  function automatic int word_at(input int inst, input int pos);
    if (inst == 0) return (NW - 1) - pos;
    return pos;
  endfunction

  function automatic logic [31:0] exp_read(input int inst, input int addr);
    int c, s;
    if (addr >= TOTAL) return 32'h0;
    c = addr / BANK;
    s = (addr - c * BANK) >> 2;
    if (s < NW) return en_m[inst][c][word_at(inst, s)];
    return src[32 * word_at(inst, s - NW) +: 32];
  endfunction

  function automatic logic [NC-1:0] exp_irq(input int inst);
    logic [NC-1:0] r;
    r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((en_m[inst][c][w] & src[32*w +: 32]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic bus_write(input int addr, input logic [31:0] d);
    int c, s;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(addr); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (addr < TOTAL) begin
      c = addr / BANK;
      s = (addr - c * BANK) >> 2;
      if (s < NW) begin
        en_m[0][c][word_at(0, s)] = d;
        en_m[1][c][word_at(1, s)] = d;
      end
    end
  endtask

  task automatic read_both(input int addr, output logic [31:0] r0, output logic [31:0] r1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(addr);
    #1;
    r0 = rdata_rev; r1 = rdata_le;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_irq(input string tag);
    chk($sformatf("%s irq reversed", tag), 32'(irq_rev), 32'(exp_irq(0)));
    chk($sformatf("%s irq natural", tag), 32'(irq_le), 32'(exp_irq(1)));
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r0, r1;
    for (int a = 0; a < TOTAL + 16; a += 4) begin
      read_both(a + (a % 3), r0, r1);   // low address bits vary, must be ignored (R2)
      chk($sformatf("%s R2 R3 rev addr %0d", tag, a), r0, exp_read(0, a));
      chk($sformatf("%s R2 R3 nat addr %0d", tag, a), r1, exp_read(1, a));
    end
    check_irq(tag);
  endtask

  initial begin
    logic [31:0] r0, r1;
    int bitsel [4] = '{0, 5, 18, 31};
    for (int i = 0; i < 2; i++)
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++) en_m[i][c][w] = '0;

    src = {32'h8000_0001, 32'h0000_F00F};
    repeat (3) @(negedge clk);
    // R8: outputs quiet while reset is held
    chk("R8 irq in reset", 32'(irq_rev | irq_le), 32'h0);
    rst_n = 1'b1;
    chk("R8 irq after release", 32'(irq_rev | irq_le), 32'h0);
    for (int a = 0; a < TOTAL; a += BANK) begin
      for (int s = 0; s < NW; s++) begin
        read_both(a + 4 * s, r0, r1);
        chk("R8 enable cleared", r0 | r1, 32'h0);
      end
    end
    settle();
    check_all("R1 status after reset");

    // R4 / R5: distinct pattern into every enable slot, then read back
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NW; s++)
        bus_write(c * BANK + 4 * s, 32'hA500_003C ^ (c << 12) ^ (s << 4));
    settle();
    check_all("R4 enable readback");
    for (int s = 0; s < NW; s++) bus_write(BANK + 4 * s, 32'h0);
    settle();
    check_all("R5 other bank kept");

    // R7: status slots ignore writes
    bus_write(NW * 4, 32'hFFFF_FFFF);
    bus_write(BANK + NW * 4 + 4, 32'hFFFF_FFFF);
    settle();
    check_all("R7 status write ignored");

    // R9: stray addresses
    bus_write(TOTAL, 32'hFFFF_FFFF);
    bus_write(TOTAL + 8, 32'h1234_5678);
    bus_write(252, 32'hFFFF_FFFF);
    settle();
    check_all("R9 stray access");

    // R1 / R3: several source patterns, status readback in both orders
    for (int p = 0; p < 4; p++) begin
      src = {32'h0102_0304 * (p + 1), 32'hF0E0_D0C0 ^ (32'h1111_1111 * p)};
      settle();
      check_all($sformatf("R1 pattern %0d", p));
    end

    // R6 / R1: single-bit enable and source per cpu, word, bit
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NW; s++) bus_write(c * BANK + 4 * s, 32'h0);
    for (int c = 0; c < NC; c++) begin
      for (int w = 0; w < NW; w++) begin
        for (int b = 0; b < 4; b++) begin
          src = '0;
          src[32 * w + bitsel[b]] = 1'b1;
          bus_write(c * BANK + 4 * ((NW - 1) - w), 32'h1 << bitsel[b]);
          settle();
          chk("R6 target cpu raised", 32'(irq_rev[c]), 32'h1);
          chk("R6 other cpu quiet", 32'(irq_rev[NC - 1 - c]), 32'h0);
          check_irq("R6 single bit");
          src[32 * w + bitsel[b]] = 1'b0;
          src[32 * ((w + 1) % NW) + bitsel[b]] = 1'b1;
          settle();
          check_irq("R6 unrelated source");
          bus_write(c * BANK + 4 * ((NW - 1) - w), 32'h0);
        end
      end
    end

    // R6 latency: enable write -> line one edge later
    src = '0; src[3] = 1'b1;
    settle();
    bus_write(4 * (NW - 1), 32'h8);          // reversed: slot NW-1 is word 0
    chk("R6 irq not yet after write edge", 32'(irq_rev[0]), 32'h0);
    @(negedge clk);
    chk("R6 irq one edge after write", 32'(irq_rev[0]), 32'h1);

    // R10 latency: source drop -> status after 2 edges, line after 3
    src[3] = 1'b0;
    @(negedge clk);
    read_both(NW * 4 + 4 * (NW - 1), r0, r1);
    chk("R10 status old after one edge", r0, 32'h8);
    @(negedge clk);
    read_both(NW * 4 + 4 * (NW - 1), r0, r1);
    chk("R10 status new after two edges", r0, 32'h0);
    chk("R10 irq still old after two edges", 32'(irq_rev[0]), 32'h1);
    @(negedge clk);
    chk("R10 irq new after three edges", 32'(irq_rev[0]), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule